// File: doc/BRIEF.md
# Power State Controller

This block is the top-level power state machine of a power-management chip. It takes already-qualified condition flags and decides when the chip may power up and when it must shut down. These flags cover supply level, overvoltage, thermal shutdown, configuration error flags, the power-on pin, watchdog requests, fault expiry and sequencer completion. It moves through fuse load, low-power off, a retried self-test, quick-power-up off, power-up, run and standby, power down and a fail-safe pass.

Its outputs go to the surrounding logic. They are the self-test and sequencer requests and the MCU reset release. They also include failure-cause bits, which are latched and cleared by writing a one, and a shutdown interrupt that belongs to a cancellable software off request. The current state is available as an encoded output. All timing windows (the self-test retry gap, the software shutdown delay and the power-on pin hold time) are counted in clock cycles set by parameters.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (fuse load), `mcu_rst_n` is 0, `shdn_irq` is 0 and `fail_cause` is 0. A `fuse_done` pulse moves to low-power off (1). With `lpm_off`=1 the block leaves low-power off for self-test (2). After a pass it waits in quick-power-up off (4) until a power-up event arrives.
- R2: A power-up event is acted on only when all of the following hold: `uv_ok` is 1, `tsd` is 0, and `trim_err`, `otp_err` and `stest_err` are all 0. It is also blocked when `ov_det` is 1, but only if both `ov_mon_en` and `ov_sdwn_en` are 1. Otherwise the event is ignored and the state stays put.
- R3: In level mode (`pwron_edge_mode`=0), `pwron` high is the power-up event. `pwron` low in run or standby starts a non-fault power down (8), which ends in low-power off (1).
- R4: In edge mode, a high-to-low transition of `pwron` is the power-up event. A turn-off needs `pwron` to stay low for HOLD_CYC consecutive cycles: the state becomes 8 on the HOLD_CYC+1-th clock edge after the pin falls. A shorter low pulse has no effect.
- R5: A failed self-test starts a gap (3) of RETRY_GAP_CYC cycles, then self-test (2) runs again. The third failure goes to the fail-safe transition (9) and then to low-power off (1). No cause bit is set by this path.
- R6: A `sw_off_set` pulse in run or standby raises `shdn_irq` on the next cycle. A `shdn_irq_clr` pulse before expiry drops `shdn_irq` and cancels the request. Without a cancel, the state becomes 8 on the SHDN_CYC+1-th edge after the set, and the power down ends in low-power off.
- R7: `mcu_rst_n` is 1 only in run (6) and standby (7). A `seq_done` pulse in power-up (5) enters run.
- R8: A `pu_fail` pulse in power-up leads to power down (8) and then the fail-safe transition (9). It sets `fail_cause` bit 0.
- R9: In run or standby, `tsd` (cause bit 3) or `fault_timer_exp`/`fault_cnt_max` (cause bit 2) lead to power down and then the fail-safe transition. These faults take priority over a simultaneous `pwron` turn-off.
- R10: Each `wd_hard_req` in run or standby increments `wd_evt_cnt`. If the new count is below `wd_max_cnt`, the power down ends in power-up (5). If the new count equals `wd_max_cnt`, the path is a fault that sets cause bit 1.
- R11: Cause bits accumulate and are retained. Writing a 1 to a `fail_clr` bit clears that bit. While `uv_ok`=0 the state is 0 and both `fail_cause` and `wd_evt_cnt` are 0.
- R12: In run, `standby_pin`=1 enters standby (7), and `standby_pin`=0 returns to run (6).
- R13: `stest_run` is 1 in self-test, `seq_up_req` is 1 in power-up, and `seq_dn_req` is 1 in power down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_ok | input | 1 | Supply above undervoltage threshold |
| fuse_done | input | 1 | Fuse load finished |
| ov_det | input | 1 | Overvoltage detected |
| ov_mon_en | input | 1 | Overvoltage monitor enabled |
| ov_sdwn_en | input | 1 | Overvoltage causes shutdown |
| tsd | input | 1 | Thermal shutdown condition |
| trim_err | input | 1 | Trim load error flag |
| otp_err | input | 1 | Configuration fuse error flag |
| stest_err | input | 1 | Self-test error flag |
| lpm_off | input | 1 | Leave low-power off automatically |
| pwron | input | 1 | Power-on pin level |
| pwron_edge_mode | input | 1 | 1: edge mode, 0: level mode |
| stest_done | input | 1 | Self-test attempt finished |
| stest_pass | input | 1 | Self-test attempt result |
| pu_fail | input | 1 | Failure during power-up sequence |
| seq_done | input | 1 | Sequencer finished |
| fault_timer_exp | input | 1 | Regulator fault timer expired |
| fault_cnt_max | input | 1 | Regulator fault count at maximum |
| wd_hard_req | input | 1 | Hard watchdog reset request |
| wd_max_cnt | input | 4 | Watchdog event limit |
| standby_pin | input | 1 | Standby request |
| sw_off_set | input | 1 | Software off request |
| shdn_irq_clr | input | 1 | Clear shutdown interrupt |
| fail_clr | input | 4 | Write-1-to-clear for cause bits |
| state_o | output | 4 | Encoded current state |
| stest_run | output | 1 | Self-test request |
| seq_up_req | output | 1 | Power-up sequencer request |
| seq_dn_req | output | 1 | Power-down sequencer request |
| mcu_rst_n | output | 1 | MCU reset release |
| shdn_irq | output | 1 | Shutdown interrupt |
| fail_cause | output | 4 | Latched causes: 0 power-up, 1 watchdog, 2 regulator, 3 thermal |
| wd_evt_cnt | output | 4 | Watchdog event count |

## Verification
The hardest cases to reach are the exits from power down, because the exit depends on why power down started. A watchdog restart has to return to power-up instead of low-power off. A cause bit must accumulate on top of bits from earlier shutdowns. The bench reaches these by running many complete power cycles in sequence: it drives the same run state into power down through each kind of event, then releases `seq_done` and checks where the block lands and which bits are set. It also finds the exact cycle boundaries of the self-test gap, the shutdown delay and the edge-mode hold by sampling one cycle before and one cycle after each expiry.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic [3:0] {
    ST_FUSE    = 4'd0,
    ST_LPOFF   = 4'd1,
    ST_STEST   = 4'd2,
    ST_SGAP    = 4'd3,
    ST_QPU     = 4'd4,
    ST_PWRUP   = 4'd5,
    ST_RUN     = 4'd6,
    ST_STBY    = 4'd7,
    ST_PWRDN   = 4'd8,
    ST_FSTRANS = 4'd9
  } pwr_state_e;

  localparam int unsigned FAIL_W = 4;
  localparam int unsigned FB_PU  = 0;
  localparam int unsigned FB_WD  = 1;
  localparam int unsigned FB_REG = 2;
  localparam int unsigned FB_TSD = 3;
endpackage

// File: rtl/pwr_event_qual.sv
module pwr_event_qual #(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_ok,
  input  logic ov_det,
  input  logic ov_mon_en,
  input  logic ov_sdwn_en,
  input  logic tsd,
  input  logic trim_err,
  input  logic otp_err,
  input  logic stest_err,
  input  logic pwron,
  input  logic edge_mode,
  output logic pu_ok,
  output logic pu_evt,
  output logic off_req,
  output logic ov_shdn
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  logic          pwron_q;
  logic [HW-1:0] hold_cnt;
  logic          hold_en;
  logic          fall;
  logic          held_low;

  assign ov_shdn  = ov_det & ov_mon_en & ov_sdwn_en;
  assign pu_ok    = uv_ok & ~ov_shdn & ~tsd & ~trim_err & ~otp_err & ~stest_err;
  assign fall     = pwron_q & ~pwron;
  assign held_low = (hold_cnt == HW'(HOLD_CYC));
  assign hold_en  = ~pwron & ~held_low;
  assign pu_evt   = edge_mode ? fall : pwron;
  assign off_req  = edge_mode ? held_low : ~pwron;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwron_q <= 1'b0;
    else        pwron_q <= pwron;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_cnt <= '0;
    else if (pwron)   hold_cnt <= '0;
    else if (hold_en) hold_cnt <= hold_cnt + 1'b1;
  end

  p_edge_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && pu_evt) |-> (!pwron && pwron_q));
  p_hold_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt != '0) |-> $past(!pwron));
endmodule

// File: rtl/pwr_stest_retry.sv
module pwr_stest_retry #(
  parameter int unsigned TRIES   = 3,
  parameter int unsigned GAP_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_test,
  input  logic in_gap,
  input  logic done,
  input  logic pass,
  output logic fail_retry,
  output logic fail_final,
  output logic gap_done
);
  localparam int unsigned TW = $clog2(TRIES + 1);
  localparam int unsigned GW = $clog2(GAP_CYC + 1);

  logic [TW-1:0] tries;
  logic [GW-1:0] gap_cnt;
  logic          fail;
  logic          last;
  logic          tries_en;
  logic          gap_en;

  assign fail       = in_test & done & ~pass;
  assign last       = (tries == TW'(TRIES - 1));
  assign fail_final = fail & last;
  assign fail_retry = fail & ~last;
  assign gap_done   = in_gap & (gap_cnt == GW'(GAP_CYC - 1));
  assign tries_en   = fail_retry;
  assign gap_en     = in_gap & ~gap_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   tries <= '0;
    else if (!(in_test | in_gap)) tries <= '0;
    else if (tries_en)            tries <= tries + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap_cnt <= '0;
    else if (!in_gap) gap_cnt <= '0;
    else if (gap_en)  gap_cnt <= gap_cnt + 1'b1;
  end

  p_tries_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TW'(TRIES));
  p_gap_cont_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_cnt != '0) |-> $past(in_gap));
endmodule

// File: rtl/pwr_sw_off_timer.sv
module pwr_sw_off_timer #(
  parameter int unsigned SHDN_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_on,
  input  logic off_set,
  input  logic irq_clr,
  output logic irq,
  output logic expire
);
  localparam int unsigned CW = $clog2(SHDN_CYC + 1);

  logic          active;
  logic [CW-1:0] cnt;

  assign expire = active & (cnt == CW'(SHDN_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      irq    <= 1'b0;
    end else if (!sys_on || (irq_clr && active)) begin
      active <= 1'b0;
      cnt    <= '0;
      irq    <= 1'b0;
    end else if (off_set && !active) begin
      active <= 1'b1;
      cnt    <= '0;
      irq    <= 1'b1;
    end else if (active && !expire) begin
      cnt    <= cnt + 1'b1;
    end
  end

  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_on && irq_clr && irq) |=> !irq);
  p_expire_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> irq);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int unsigned RETRY_GAP_CYC = 20,
  parameter int unsigned SHDN_CYC      = 50,
  parameter int unsigned HOLD_CYC      = 16,
  parameter int unsigned STEST_TRIES   = 3,
  parameter int unsigned WD_W          = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_ok,
  input  logic              fuse_done,
  input  logic              ov_det,
  input  logic              ov_mon_en,
  input  logic              ov_sdwn_en,
  input  logic              tsd,
  input  logic              trim_err,
  input  logic              otp_err,
  input  logic              stest_err,
  input  logic              lpm_off,
  input  logic              pwron,
  input  logic              pwron_edge_mode,
  input  logic              stest_done,
  input  logic              stest_pass,
  input  logic              pu_fail,
  input  logic              seq_done,
  input  logic              fault_timer_exp,
  input  logic              fault_cnt_max,
  input  logic              wd_hard_req,
  input  logic [WD_W-1:0]   wd_max_cnt,
  input  logic              standby_pin,
  input  logic              sw_off_set,
  input  logic              shdn_irq_clr,
  input  logic [FAIL_W-1:0] fail_clr,
  output logic [3:0]        state_o,
  output logic              stest_run,
  output logic              seq_up_req,
  output logic              seq_dn_req,
  output logic              mcu_rst_n,
  output logic              shdn_irq,
  output logic [FAIL_W-1:0] fail_cause,
  output logic [WD_W-1:0]   wd_evt_cnt
);
  pwr_state_e        state, nxt;
  logic              dn_fault, nxt_fault;
  logic              dn_restart, nxt_restart;
  logic [FAIL_W-1:0] dn_cause, nxt_cause;
  logic              pu_pend, nxt_pend;

  logic pu_ok, pu_evt, off_req, ov_shdn;
  logic st_retry, st_final, gap_done;
  logic shdn_exp, sys_on;
  logic reg_fault, wd_take, wd_hit, enter_fs;
  logic [WD_W-1:0] wd_inc;

  assign sys_on     = (state == ST_RUN) || (state == ST_STBY);
  assign state_o    = state;
  assign stest_run  = (state == ST_STEST);
  assign seq_up_req = (state == ST_PWRUP);
  assign seq_dn_req = (state == ST_PWRDN);
  assign mcu_rst_n  = sys_on;

  pwr_event_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .ov_det(ov_det),
    .ov_mon_en(ov_mon_en), .ov_sdwn_en(ov_sdwn_en), .tsd(tsd),
    .trim_err(trim_err), .otp_err(otp_err), .stest_err(stest_err),
    .pwron(pwron), .edge_mode(pwron_edge_mode), .pu_ok(pu_ok),
    .pu_evt(pu_evt), .off_req(off_req), .ov_shdn(ov_shdn)
  );

  pwr_stest_retry #(.TRIES(STEST_TRIES), .GAP_CYC(RETRY_GAP_CYC)) u_retry (
    .clk(clk), .rst_n(rst_n), .in_test(state == ST_STEST),
    .in_gap(state == ST_SGAP), .done(stest_done), .pass(stest_pass),
    .fail_retry(st_retry), .fail_final(st_final), .gap_done(gap_done)
  );

  pwr_sw_off_timer #(.SHDN_CYC(SHDN_CYC)) u_swoff (
    .clk(clk), .rst_n(rst_n), .sys_on(sys_on), .off_set(sw_off_set),
    .irq_clr(shdn_irq_clr), .irq(shdn_irq), .expire(shdn_exp)
  );

  // Watchdog event counting: the incremented value is compared before the branch.
  assign reg_fault = fault_timer_exp | fault_cnt_max;
  assign wd_inc    = (wd_evt_cnt == '1) ? wd_evt_cnt : wd_evt_cnt + 1'b1;
  assign wd_hit    = (wd_inc == wd_max_cnt);
  assign wd_take   = uv_ok & sys_on & wd_hard_req & ~tsd & ~reg_fault;

  always_comb begin
    nxt         = state;
    nxt_fault   = dn_fault;
    nxt_restart = dn_restart;
    nxt_cause   = dn_cause;
    nxt_pend    = pu_pend;
    unique case (state)
      ST_FUSE: if (fuse_done) nxt = ST_LPOFF;
      ST_LPOFF: begin
        nxt_pend = 1'b0;
        if (pu_evt && pu_ok) begin
          nxt      = ST_STEST;
          nxt_pend = 1'b1;
        end else if (lpm_off) begin
          nxt = ST_STEST;
        end
      end
      ST_STEST: begin
        if (st_final) begin
          nxt       = ST_FSTRANS;
          nxt_cause = '0;
        end else if (st_retry) begin
          nxt = ST_SGAP;
        end else if (stest_done && stest_pass) begin
          nxt = ST_QPU;
        end
      end
      ST_SGAP: if (gap_done) nxt = ST_STEST;
      ST_QPU: begin
        if ((pu_pend || pu_evt) && pu_ok) begin
          nxt         = ST_PWRUP;
          nxt_pend    = 1'b0;
          nxt_fault   = 1'b0;
          nxt_restart = 1'b0;
          nxt_cause   = '0;
        end
      end
      ST_PWRUP: begin
        if (pu_fail) begin
          nxt              = ST_PWRDN;
          nxt_fault        = 1'b1;
          nxt_cause        = '0;
          nxt_cause[FB_PU] = 1'b1;
        end else if (ov_shdn) begin
          nxt       = ST_PWRDN;
          nxt_fault = 1'b0;
        end else if (seq_done) begin
          nxt = ST_RUN;
        end
      end
      ST_RUN, ST_STBY: begin
        nxt_cause = '0;
        if (tsd) begin
          nxt               = ST_PWRDN;
          nxt_fault         = 1'b1;
          nxt_cause[FB_TSD] = 1'b1;
        end else if (reg_fault) begin
          nxt               = ST_PWRDN;
          nxt_fault         = 1'b1;
          nxt_cause[FB_REG] = 1'b1;
        end else if (wd_hard_req) begin
          nxt = ST_PWRDN;
          if (wd_hit) begin
            nxt              = ST_PWRDN;
            nxt_fault        = 1'b1;
            nxt_cause[FB_WD] = 1'b1;
          end else begin
            nxt_fault   = 1'b0;
            nxt_restart = 1'b1;
          end
        end else if (off_req || shdn_exp || ov_shdn) begin
          nxt       = ST_PWRDN;
          nxt_fault = 1'b0;
        end else begin
          nxt = standby_pin ? ST_STBY : ST_RUN;
        end
      end
      ST_PWRDN: begin
        if (seq_done) begin
          if (dn_fault) begin
            nxt = ST_FSTRANS;
          end else if (dn_restart) begin
            nxt         = ST_PWRUP;
            nxt_restart = 1'b0;
          end else begin
            nxt = ST_LPOFF;
          end
        end
      end
      ST_FSTRANS: nxt = ST_LPOFF;
      default:    nxt = ST_FUSE;
    endcase
    if (!uv_ok) begin
      nxt         = ST_FUSE;
      nxt_pend    = 1'b0;
      nxt_fault   = 1'b0;
      nxt_restart = 1'b0;
      nxt_cause   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_FUSE;
      dn_fault   <= 1'b0;
      dn_restart <= 1'b0;
      dn_cause   <= '0;
      pu_pend    <= 1'b0;
    end else begin
      state      <= nxt;
      dn_fault   <= nxt_fault;
      dn_restart <= nxt_restart;
      dn_cause   <= nxt_cause;
      pu_pend    <= nxt_pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wd_evt_cnt <= '0;
    else if (!uv_ok)  wd_evt_cnt <= '0;
    else if (wd_take) wd_evt_cnt <= wd_inc;
  end

  assign enter_fs = (state == ST_PWRDN) && (nxt == ST_FSTRANS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fail_cause <= '0;
    else if (!uv_ok) fail_cause <= '0;
    else             fail_cause <= (fail_cause & ~fail_clr) | (enter_fs ? dn_cause : '0);
  end

  p_pu_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PWRUP && $past(state) == ST_QPU) |-> $past(pu_ok));
  p_rst_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mcu_rst_n) |-> ($past(state) == ST_PWRUP));
  p_fs_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FSTRANS) |-> ($past(state) == ST_PWRDN || $past(state) == ST_STEST));
  p_fail_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_ok && fail_clr == '0) |=> ((fail_cause & $past(fail_cause)) == $past(fail_cause)));
  p_wd_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uv_ok |=> (wd_evt_cnt >= $past(wd_evt_cnt)));
  p_uv_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok |=> (state == ST_FUSE && fail_cause == '0));
endmodule

// File: tb/pwr_state_ctrl_bench.sv
module pwr_state_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP  = 12;
  localparam int SHDN = 30;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic uv_ok, fuse_done, ov_det, ov_mon_en, ov_sdwn_en, tsd, trim_err, otp_err;
  logic stest_err, lpm_off, pwron, pwron_edge_mode, stest_done, stest_pass;
  logic pu_fail, seq_done, fault_timer_exp, fault_cnt_max, wd_hard_req;
  logic [3:0] wd_max_cnt;
  logic standby_pin, sw_off_set, shdn_irq_clr;
  logic [3:0] fail_clr;
  logic [3:0] state_o;
  logic stest_run, seq_up_req, seq_dn_req, mcu_rst_n, shdn_irq;
  logic [3:0] fail_cause, wd_evt_cnt;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctrl #(.RETRY_GAP_CYC(GAP), .SHDN_CYC(SHDN), .HOLD_CYC(HOLD),
                   .STEST_TRIES(3), .WD_W(4)) u_pwr_state_ctrl (
    .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .fuse_done(fuse_done),
    .ov_det(ov_det), .ov_mon_en(ov_mon_en), .ov_sdwn_en(ov_sdwn_en), .tsd(tsd),
    .trim_err(trim_err), .otp_err(otp_err), .stest_err(stest_err),
    .lpm_off(lpm_off), .pwron(pwron), .pwron_edge_mode(pwron_edge_mode),
    .stest_done(stest_done), .stest_pass(stest_pass), .pu_fail(pu_fail),
    .seq_done(seq_done), .fault_timer_exp(fault_timer_exp),
    .fault_cnt_max(fault_cnt_max), .wd_hard_req(wd_hard_req),
    .wd_max_cnt(wd_max_cnt), .standby_pin(standby_pin), .sw_off_set(sw_off_set),
    .shdn_irq_clr(shdn_irq_clr), .fail_clr(fail_clr), .state_o(state_o),
    .stest_run(stest_run), .seq_up_req(seq_up_req), .seq_dn_req(seq_dn_req),
    .mcu_rst_n(mcu_rst_n), .shdn_irq(shdn_irq), .fail_cause(fail_cause),
    .wd_evt_cnt(wd_evt_cnt)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_seq_done();
    seq_done = 1'b1; tick(1); seq_done = 1'b0;
  endtask

  task automatic st_pass();
    stest_done = 1'b1; stest_pass = 1'b1; tick(1);
    stest_done = 1'b0; stest_pass = 1'b0;
  endtask

  task automatic power_up_level();
    pwron = 1'b1; tick(1);
    chk("R3 self-test after pwron high", state_o, 2);
    chk("R13 stest_run", stest_run, 1);
    st_pass();
    chk("R1 quick-power-up off", state_o, 4);
    tick(1);
    chk("R3 power-up", state_o, 5);
    chk("R13 seq_up_req", seq_up_req, 1);
    chk("R7 reset held in power-up", mcu_rst_n, 0);
    pulse_seq_done();
    chk("R7 run", state_o, 6);
    chk("R7 reset released", mcu_rst_n, 1);
  endtask

  task automatic t_reset();
    chk("R1 reset state", state_o, 0);
    chk("R1 reset mcu", mcu_rst_n, 0);
    chk("R1 reset irq", shdn_irq, 0);
    chk("R1 reset fail", fail_cause, 0);
    fuse_done = 1'b1; tick(1); fuse_done = 1'b0;
    chk("R1 low-power off", state_o, 1);
  endtask

  task automatic t_blocked();
    tsd = 1'b1; pwron = 1'b1; tick(4);
    chk("R2 blocked by tsd", state_o, 1);
    tsd = 1'b0; trim_err = 1'b1; tick(3);
    chk("R2 blocked by trim_err", state_o, 1);
    trim_err = 1'b0; stest_err = 1'b1; tick(3);
    chk("R2 blocked by stest_err", state_o, 1);
    stest_err = 1'b0; ov_det = 1'b1; ov_mon_en = 1'b1; ov_sdwn_en = 1'b1; tick(3);
    chk("R2 blocked by overvoltage", state_o, 1);
    ov_mon_en = 1'b0; tick(1);
    chk("R2 overvoltage ignored with monitor off", state_o, 2);
    ov_det = 1'b0; ov_sdwn_en = 1'b0;
  endtask

  task automatic t_retry();
    pwron = 1'b0;
    for (int k = 0; k < 2; k++) begin
      stest_done = 1'b1; tick(1); stest_done = 1'b0;
      chk("R5 gap entered", state_o, 3);
      tick(GAP - 1);
      chk("R5 still in gap", state_o, 3);
      tick(1);
      chk("R5 retry after gap", state_o, 2);
    end
    stest_done = 1'b1; tick(1); stest_done = 1'b0;
    chk("R5 third failure fail-safe", state_o, 9);
    tick(1);
    chk("R5 fail-safe to low-power off", state_o, 1);
    chk("R5 no cause bit", fail_cause, 0);
    tick(3);
    chk("R5 stays off", state_o, 1);
  endtask

  task automatic t_standby();
    standby_pin = 1'b1; tick(1);
    chk("R12 standby", state_o, 7);
    chk("R7 reset released in standby", mcu_rst_n, 1);
    standby_pin = 1'b0; tick(1);
    chk("R12 back to run", state_o, 6);
  endtask

  task automatic t_swoff();
    sw_off_set = 1'b1; tick(1); sw_off_set = 1'b0;
    chk("R6 irq raised", shdn_irq, 1);
    tick(10);
    shdn_irq_clr = 1'b1; tick(1); shdn_irq_clr = 1'b0;
    chk("R6 irq cleared", shdn_irq, 0);
    tick(SHDN + 5);
    chk("R6 cancel keeps run", state_o, 6);
    sw_off_set = 1'b1; tick(1); sw_off_set = 1'b0;
    tick(SHDN - 1);
    chk("R6 before expiry", state_o, 6);
    tick(1);
    chk("R6 expiry power down", state_o, 8);
    chk("R13 seq_dn_req", seq_dn_req, 1);
    pulse_seq_done();
    chk("R6 non-fault to low-power off", state_o, 1);
    pwron = 1'b0;
    chk("R6 no cause", fail_cause, 0);
  endtask

  task automatic t_level_off();
    power_up_level();
    pwron = 1'b0; tick(1);
    chk("R3 pwron low powers down", state_o, 8);
    chk("R7 reset asserted in power down", mcu_rst_n, 0);
    pulse_seq_done();
    chk("R3 to low-power off", state_o, 1);
  endtask

  task automatic t_edge();
    pwron_edge_mode = 1'b1; pwron = 1'b1; tick(3);
    chk("R4 high level no event", state_o, 1);
    pwron = 1'b0; tick(1);
    chk("R4 falling edge starts", state_o, 2);
    pwron = 1'b1;
    st_pass(); tick(1);
    chk("R4 power-up", state_o, 5);
    pulse_seq_done();
    chk("R4 run", state_o, 6);
    pwron = 1'b0; tick(3); pwron = 1'b1; tick(2);
    chk("R4 short low ignored", state_o, 6);
    pwron = 1'b0; tick(HOLD);
    chk("R4 not yet held", state_o, 6);
    tick(1);
    chk("R4 held low turns off", state_o, 8);
    pulse_seq_done();
    chk("R4 to low-power off", state_o, 1);
    pwron_edge_mode = 1'b0;
  endtask

  task automatic t_pu_fail();
    pwron = 1'b1; tick(1);
    st_pass(); tick(1);
    chk("R8 in power-up", state_o, 5);
    pu_fail = 1'b1; tick(1); pu_fail = 1'b0;
    chk("R8 power down", state_o, 8);
    pwron = 1'b0;
    pulse_seq_done();
    chk("R8 fail-safe", state_o, 9);
    tick(1);
    chk("R8 low-power off", state_o, 1);
    chk("R8 cause bit0", fail_cause, 1);
    fail_clr = 4'b0001; tick(1); fail_clr = 4'b0000;
    chk("R11 write-1 clear", fail_cause, 0);
  endtask

  task automatic t_faults();
    power_up_level();
    tsd = 1'b1; pwron = 1'b0; tick(1); tsd = 1'b0;
    chk("R9 thermal power down", state_o, 8);
    pulse_seq_done();
    chk("R9 thermal fail-safe", state_o, 9);
    tick(1);
    chk("R9 thermal cause", fail_cause, 8);
    power_up_level();
    fault_timer_exp = 1'b1; pwron = 1'b0; tick(1); fault_timer_exp = 1'b0;
    chk("R9 regulator power down", state_o, 8);
    pulse_seq_done(); tick(1);
    chk("R9 regulator to low-power off", state_o, 1);
    chk("R11 causes accumulate", fail_cause, 12);
  endtask

  task automatic t_wd();
    wd_max_cnt = 4'd2;
    power_up_level();
    wd_hard_req = 1'b1; tick(1); wd_hard_req = 1'b0;
    chk("R10 wd power down", state_o, 8);
    chk("R10 count 1", wd_evt_cnt, 1);
    pulse_seq_done();
    chk("R10 restart to power-up", state_o, 5);
    pulse_seq_done();
    chk("R10 run again", state_o, 6);
    wd_hard_req = 1'b1; tick(1); wd_hard_req = 1'b0;
    chk("R10 count 2", wd_evt_cnt, 2);
    pwron = 1'b0;
    pulse_seq_done();
    chk("R10 max to fail-safe", state_o, 9);
    tick(1);
    chk("R10 low-power off", state_o, 1);
    chk("R10 watchdog cause", fail_cause, 14);
  endtask

  task automatic t_uv();
    uv_ok = 1'b0; tick(1);
    chk("R11 supply loss state", state_o, 0);
    chk("R11 supply loss clears causes", fail_cause, 0);
    chk("R11 supply loss clears wd count", wd_evt_cnt, 0);
    uv_ok = 1'b1; tick(2);
    chk("R1 waits for fuse load", state_o, 0);
    fuse_done = 1'b1; tick(1); fuse_done = 1'b0;
    chk("R1 low-power off again", state_o, 1);
    lpm_off = 1'b1; tick(1);
    chk("R1 automatic self-test", state_o, 2);
    st_pass(); tick(5);
    chk("R1 waits in quick-power-up off", state_o, 4);
    pwron = 1'b1; tick(1);
    chk("R1 event from quick-power-up off", state_o, 5);
    pulse_seq_done();
    chk("R7 run from quick path", state_o, 6);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; uv_ok = 1'b1; fuse_done = 1'b0; ov_det = 1'b0; ov_mon_en = 1'b0;
    ov_sdwn_en = 1'b0; tsd = 1'b0; trim_err = 1'b0; otp_err = 1'b0; stest_err = 1'b0;
    lpm_off = 1'b0; pwron = 1'b0; pwron_edge_mode = 1'b0; stest_done = 1'b0;
    stest_pass = 1'b0; pu_fail = 1'b0; seq_done = 1'b0; fault_timer_exp = 1'b0;
    fault_cnt_max = 1'b0; wd_hard_req = 1'b0; wd_max_cnt = 4'd0; standby_pin = 1'b0;
    sw_off_set = 1'b0; shdn_irq_clr = 1'b0; fail_clr = 4'b0000;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_blocked();
    t_retry();
    power_up_level();
    t_standby();
    t_swoff();
    t_level_off();
    t_edge();
    t_pu_fail();
    t_faults();
    t_wd();
    t_uv();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule